// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Cell

This block is one programmable-logic output cell. An AND plane builds product terms from a vector of input literals. Each literal can be used in its true form, in its complemented form, or not at all. One extra literal is fed back from the cell's own register. A group of product terms is ORed into a sum. The sum can be XORed with a dedicated product term. The result then reaches the pin either directly or through a D register, with selectable polarity and an output-enable flag.

The register normally runs on the global clock and the global asynchronous reset. Two further dedicated product terms can take over as the register's clock and as its asynchronous clear. All choices come from one static configuration vector on a port. Loading and storing that vector is done elsewhere. High impedance is reported as a flag, not as a tri-state net.

Top module: `sop_macrocell`

## Requirements
- R1: Product term k is configured by `cfg[k*2L +: 2L]`, where L = N_IN+1. Bit 2j connects literal j in true form and bit 2j+1 connects it in complemented form. Literal j < N_IN is `lit_in[j]` and literal N_IN is the feedback literal. A product term is the AND of all its connected literal forms.
- R2: A product term with no connected literal evaluates to 0.
- R3: Terms 0 to N_SUM-1 (N_SUM from 1 to 20) are ORed into the sum.
- R4: With the XOR-enable bit (`cfg[P+2]`, where P = (N_SUM+3)*2L) set, the cell value is the sum XOR term N_SUM. With the bit clear, term N_SUM is not used.
- R5: With the register-select bit `cfg[P+0]` clear, the outputs follow the inputs in the same cycle, with no clock edge.
- R6: With `cfg[P+0]` set, the cell value is taken on a rising clock edge and holds between edges.
- R7: The invert bit `cfg[P+1]` inverts `pin_out` only. `fb_out` is never inverted.
- R8: With the enable bit `cfg[P+5]` clear, `pin_oe` is 0 and `pin_out` is 0. `fb_out` still reports the cell value.
- R9: The feedback literal is the register output. `fb_out` is the register output in registered mode and the combinational value in combinational mode.
- R10: With `cfg[P+3]` set, the register is clocked by rising edges of term N_SUM+1, and the global clock has no effect on it.
- R11: With `cfg[P+4]` set, term N_SUM+2 high clears the register to 0 at once, without a clock edge. The clear is applied before the polarity inversion.
- R12: `rst_n` low clears the register asynchronously. After `rst_n` rises, the register captures data from the third rising clock edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| rst_n | input | 1 | Global active-low reset |
| lit_in | input | N_IN | Input literals |
| cfg | input | CFG_W | Static configuration: AND plane, then 6 mode bits |
| pin_out | output | 1 | Pin value; 0 when not driven |
| pin_oe | output | 1 | 1 = pin driven, 0 = high impedance |
| fb_out | output | 1 | Cell value before polarity (feedback) |

## Verification
In combinational mode the outputs are due in the same cycle. The bench changes inputs on the falling edge and samples 2 ns later, before any rising edge can matter. In registered mode the result is due after the next rising edge. The bench samples just after that edge and also checks just before it that the old value still holds. A product-term clear acts without any edge and is checked 1 ns after the input change. A product-term clock acts on the literal's rising edge and is checked 1 ns after it. After reset release, the bench expects 0 after the second rising edge and data after the third.

// File: rtl/macrocell_pkg.sv
package macrocell_pkg;
  localparam int MODE_W = 6;
  // bit 0 of the mode field is reg_en, bit 5 is oe_en
  typedef struct packed {
    logic oe_en;
    logic ptrst_en;
    logic ptclk_en;
    logic xor_en;
    logic inv_en;
    logic reg_en;
  } mode_t;
endpackage

// File: rtl/macrocell_rst_sync.sv
module macrocell_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/macrocell_and_plane.sv
module macrocell_and_plane #(
  parameter int N_LIT = 5,
  parameter int N_PT  = 7,
  localparam int ROW_W = 2 * N_LIT
) (
  input  logic [N_LIT-1:0]      lits,
  input  logic [N_PT*ROW_W-1:0] mask,
  output logic [N_PT-1:0]       pt
);
  logic [ROW_W-1:0] lit_pair;

  genvar j, k;
  generate
    for (j = 0; j < N_LIT; j++) begin : g_lit
      assign lit_pair[2*j]   = lits[j];
      assign lit_pair[2*j+1] = ~lits[j];
    end
    for (k = 0; k < N_PT; k++) begin : g_term
      logic [ROW_W-1:0] row;
      assign row   = mask[k*ROW_W +: ROW_W];
      // an empty row yields 0 instead of the AND identity
      assign pt[k] = (|row) & (&(lit_pair | ~row));
    end
  endgenerate
endmodule

// File: rtl/macrocell_out_cell.sv
module macrocell_out_cell
  import macrocell_pkg::*;
#(
  parameter int N_SUM = 4
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic [N_SUM-1:0] pt_sum,
  input  logic             pt_xor,
  input  logic             pt_clk,
  input  logic             pt_rst,
  input  mode_t            mode,
  output logic             q,
  output logic             d_val,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             fb_out
);
  logic sum_w;
  logic q_nxt;
  logic reg_clk;
  logic reg_rst_n;
  logic core;

  always_comb begin
    sum_w = |pt_sum;
    d_val = mode.xor_en ? (sum_w ^ pt_xor) : sum_w;
    q_nxt = d_val;
  end

  assign reg_clk   = mode.ptclk_en ? pt_clk : clk;
  assign reg_rst_n = rst_q_n & ~(mode.ptrst_en & pt_rst);

  always_ff @(posedge reg_clk or negedge reg_rst_n) begin
    if (!reg_rst_n) q <= 1'b0;
    else            q <= q_nxt;
  end

  always_comb begin
    core    = mode.reg_en ? q : d_val;
    fb_out  = core;
    pin_oe  = mode.oe_en;
    pin_out = mode.oe_en & (core ^ mode.inv_en);
  end
endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
  import macrocell_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_SUM = 4,
  parameter int CFG_W = (N_SUM + 3) * 2 * (N_IN + 1) + 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  lit_in,
  input  logic [CFG_W-1:0] cfg,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             fb_out
);
  localparam int N_LIT   = N_IN + 1;
  localparam int N_PT    = N_SUM + 3;
  localparam int PLANE_W = N_PT * 2 * N_LIT;
  localparam int PT_XOR  = N_SUM;
  localparam int PT_CLK  = N_SUM + 1;
  localparam int PT_RST  = N_SUM + 2;

  logic             rst_q_n;
  logic             q;
  logic             d_val;
  logic [N_LIT-1:0] lits;
  logic [N_PT-1:0]  pt_vec;
  mode_t            mode;

  assign mode = mode_t'(cfg[PLANE_W +: MODE_W]);
  assign lits = {q, lit_in};

  macrocell_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  macrocell_and_plane #(.N_LIT(N_LIT), .N_PT(N_PT)) u_plane (
    .lits (lits),
    .mask (cfg[PLANE_W-1:0]),
    .pt   (pt_vec)
  );

  macrocell_out_cell #(.N_SUM(N_SUM)) u_out (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .pt_sum  (pt_vec[N_SUM-1:0]),
    .pt_xor  (pt_vec[PT_XOR]),
    .pt_clk  (pt_vec[PT_CLK]),
    .pt_rst  (pt_vec[PT_RST]),
    .mode    (mode),
    .q       (q),
    .d_val   (d_val),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .fb_out  (fb_out)
  );
endmodule

// File: rtl/macrocell_checker.sv
module macrocell_checker #(
  parameter int N_IN  = 4,
  parameter int N_SUM = 4,
  parameter int CFG_W = (N_SUM + 3) * 2 * (N_IN + 1) + 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_q_n,
  input logic [CFG_W-1:0] cfg,
  input logic [N_SUM+2:0] pt_vec,
  input logic             d_val,
  input logic             pin_out,
  input logic             pin_oe,
  input logic             fb_out
);
  localparam int ROW_W = 2 * (N_IN + 1);
  localparam int P     = (N_SUM + 3) * ROW_W;

  logic m_reg, m_inv, m_xor, m_pclk, m_prst, m_oe;
  assign m_reg  = cfg[P];
  assign m_inv  = cfg[P+1];
  assign m_xor  = cfg[P+2];
  assign m_pclk = cfg[P+3];
  assign m_prst = cfg[P+4];
  assign m_oe   = cfg[P+5];

  AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !m_oe |-> (!pin_oe && !pin_out)); // R8
  AST_PIN_POLARITY: assert property (@(posedge clk) disable iff (!rst_n) m_oe |-> (pin_out == (fb_out ^ m_inv))); // R7
  AST_COMB_SUM: assert property (@(posedge clk) disable iff (!rst_n) (!m_reg && !m_xor) |-> (fb_out == |pt_vec[N_SUM-1:0])); // R3
  AST_XOR_PATH: assert property (@(posedge clk) disable iff (!rst_n) (!m_reg && m_xor) |-> (fb_out == ((|pt_vec[N_SUM-1:0]) ^ pt_vec[N_SUM]))); // R4
  AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_q_n) (m_reg && !m_pclk && !m_prst && $past(rst_q_n) && $stable(cfg)) |-> (fb_out == $past(d_val))); // R6
  AST_PTRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (m_reg && m_prst && pt_vec[N_SUM+2]) |-> !fb_out); // R11
  AST_EMPTY_TERM: assert property (@(posedge clk) disable iff (!rst_n) (cfg[ROW_W-1:0] == '0) |-> !pt_vec[0]); // R2
endmodule

bind sop_macrocell macrocell_checker #(.N_IN(N_IN), .N_SUM(N_SUM), .CFG_W(CFG_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rst_q_n (rst_q_n),
  .cfg     (cfg),
  .pt_vec  (pt_vec),
  .d_val   (d_val),
  .pin_out (pin_out),
  .pin_oe  (pin_oe),
  .fb_out  (fb_out)
);

// File: tb/sop_macrocell_test.sv
`timescale 1ns/1ps
module sop_macrocell_test;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  localparam int NS = 4;
  localparam int RW = 2 * (NI + 1);
  localparam int PW = (NS + 3) * RW;
  localparam int CW = PW + 6;
  localparam int B_REG = PW, B_INV = PW + 1, B_XOR = PW + 2;
  localparam int B_PCLK = PW + 3, B_PRST = PW + 4, B_OE = PW + 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NI-1:0] lit_in;
  logic [CW-1:0] cfg;
  logic          pin_out, pin_oe, fb_out;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] seed = 32'h1d2c_3b4a;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sop_macrocell #(.N_IN(NI), .N_SUM(NS)) uut (
    .clk(clk), .rst_n(rst_n), .lit_in(lit_in), .cfg(cfg),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
  );

  task automatic check(input logic got, input logic exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
    end
  endtask

  function automatic logic [31:0] next_rand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic bit ref_pt(logic [CW-1:0] c, int k, logic [NI-1:0] x, bit fb);
    bit any = 0;
    bit r = 1;
    for (int j = 0; j <= NI; j++) begin
      bit lv = (j < NI) ? x[j] : fb;
      if (c[k*RW + 2*j])   begin any = 1; r = r & lv;  end
      if (c[k*RW + 2*j+1]) begin any = 1; r = r & ~lv; end
    end
    return any & r;
  endfunction

  function automatic bit ref_core(logic [CW-1:0] c, logic [NI-1:0] x, bit fb);
    bit s = 0;
    for (int k = 0; k < NS; k++) s = s | ref_pt(c, k, x, fb);
    if (c[B_XOR]) s = s ^ ref_pt(c, NS, x, fb);
    return s;
  endfunction

  function automatic logic [CW-1:0] rand_plane();
    logic [CW-1:0] c = '0;
    for (int w = 0; w < 3; w++) begin
      logic [31:0] a = next_rand();
      logic [31:0] b = next_rand();
      for (int i = 0; i < 32; i++)
        if (w*32 + i < PW) c[w*32 + i] = a[i] & b[i];
    end
    for (int k = 0; k < NS + 3; k++) begin
      c[k*RW + 2*NI]   = 1'b0;
      c[k*RW + 2*NI+1] = 1'b0;
    end
    return c;
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    logic [CW-1:0] c;
    bit prev;
    // reset state and release timing (R12)
    rst_n = 1'b0;
    lit_in = 4'b0001;
    cfg = '0; cfg[0] = 1'b1; cfg[B_REG] = 1'b1; cfg[B_OE] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pin_out, 1'b0, "R12", "pin in reset");
    check(fb_out, 1'b0, "R12", "fb in reset");
    check(pin_oe, 1'b1, "R8", "oe in reset");
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(fb_out, 1'b0, "R12", "second edge after release");
    @(posedge clk); @(negedge clk);
    check(fb_out, 1'b1, "R12", "third edge after release");

    // combinational sweep (R1 R2 R3 R4 R5 R7)
    for (int ci = 0; ci < 24; ci++) begin
      c = (ci == 0) ? '0 : rand_plane();
      if (ci == 1) begin
        c[PW-1:0] = '0;
        c[0*RW + 0] = 1; c[0*RW + 3] = 1;   // in0 & ~in1
        c[1*RW + 4] = 1; c[1*RW + 6] = 1;   // in2 & in3
        c[NS*RW + 7] = 1;                   // xor term ~in3
      end
      c[B_REG] = 0; c[B_PCLK] = 0; c[B_PRST] = 0; c[B_OE] = 1;
      c[B_INV] = ci[1];
      c[B_XOR] = ci[0];
      cfg = c;
      for (int x = 0; x < 16; x++) begin
        @(negedge clk);
        lit_in = x[NI-1:0];
        #2;
        prev = ref_core(c, x[NI-1:0], 1'b0);
        check(fb_out, prev, c[B_XOR] ? "R4" : (ci == 0 ? "R2" : "R1/R3"), "comb value");
        check(pin_out, prev ^ c[B_INV], "R5", "pin same cycle (R7 polarity)");
      end
    end

    // registered sweep (R6)
    for (int ci = 0; ci < 8; ci++) begin
      c = rand_plane();
      c[B_REG] = 1; c[B_PCLK] = 0; c[B_PRST] = 0; c[B_OE] = 1;
      c[B_INV] = ci[0]; c[B_XOR] = ci[1];
      cfg = c;
      for (int x = 0; x < 16; x++) begin
        @(negedge clk);
        lit_in = x[NI-1:0];
        #1;
        if (x > 0) check(fb_out, prev, "R6", "hold before edge");
        prev = ref_core(c, x[NI-1:0], 1'b0);
        @(posedge clk); #2;
        check(fb_out, prev, "R6", "captured after edge");
        check(pin_out, prev ^ c[B_INV], "R7", "registered polarity");
      end
    end

    // feedback toggle, registered then combinational (R9)
    for (int m = 0; m < 2; m++) begin
      c = '0; c[2*NI+1] = 1'b1;          // term 0 = ~feedback
      c[B_REG] = (m == 0); c[B_OE] = 1;
      cfg = c;
      lit_in = '0;
      @(negedge clk);
      prev = fb_out;
      for (int t = 0; t < 6; t++) begin
        @(negedge clk);
        check(fb_out, ~prev, "R9", m == 0 ? "registered toggle" : "comb toggle");
        prev = fb_out;
      end
    end

    // output enable (R8)
    c = '0; c[0] = 1'b1; c[B_OE] = 1'b0;
    cfg = c;
    @(negedge clk); lit_in = 4'b0001; #2;
    check(pin_oe, 1'b0, "R8", "oe off");
    check(pin_out, 1'b0, "R8", "pin quiet");
    check(fb_out, 1'b1, "R8", "fb still reports");
    cfg[B_OE] = 1'b1; #1;
    check(pin_oe, 1'b1, "R8", "oe on");
    check(pin_out, 1'b1, "R8", "pin driven");

    // product-term clock (R10): term NS+1 = in3
    c = '0; c[0] = 1'b1; c[(NS+1)*RW + 6] = 1'b1;
    c[B_REG] = 1; c[B_PCLK] = 1; c[B_OE] = 1;
    cfg = c;
    @(negedge clk); lit_in = 4'b0000;
    @(negedge clk); lit_in = 4'b1000; #1;
    check(fb_out, 1'b0, "R10", "term clock loads 0");
    @(negedge clk); lit_in = 4'b0001;
    repeat (2) @(posedge clk); #2;
    check(fb_out, 1'b0, "R10", "global clock ignored");
    @(negedge clk); lit_in = 4'b1001; #1;
    check(fb_out, 1'b1, "R10", "term clock loads 1");

    // product-term reset (R11): term NS+2 = in2, inverted pin
    c = '0; c[0] = 1'b1; c[(NS+2)*RW + 4] = 1'b1;
    c[B_REG] = 1; c[B_PRST] = 1; c[B_INV] = 1; c[B_OE] = 1;
    cfg = c;
    @(negedge clk); lit_in = 4'b0001;
    @(posedge clk); #2;
    check(fb_out, 1'b1, "R11", "loaded before clear");
    check(pin_out, 1'b0, "R11", "inverted before clear");
    @(negedge clk); lit_in = 4'b0101; #1;
    check(fb_out, 1'b0, "R11", "cleared without edge");
    check(pin_out, 1'b1, "R11", "clear before polarity");
    @(posedge clk); #2;
    check(fb_out, 1'b0, "R11", "held clear across edge");
    @(negedge clk); lit_in = 4'b0001;
    @(posedge clk); #2;
    check(fb_out, 1'b1, "R11", "loads after clear ends");

    // asynchronous global reset (R12)
    @(negedge clk); rst_n = 1'b0; #1;
    check(fb_out, 1'b0, "R12", "async clear");
    rst_n = 1'b1;

    done = 1;
    finish_run();
  end
endmodule